// File: doc/BRIEF.md
# Bit-Slice Integer ALU with Zero, Overflow and Carry Flags

This block is a purely combinational integer arithmetic logic unit for a processor execute stage. It takes two operands of parameterised width (32 bits by default) and a 3-bit function code. It returns a result word and three flags: an all-zero indication, a signed-overflow indication and the carry out of the adder. The supported functions are bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than.

The datapath is a row of identical one-bit slices. Each slice forms its own AND, OR, carry-generate and carry-propagate terms. A multiplexer inside the slice then picks that bit's output. The top bit of the function code inverts operand B and also supplies the carry into bit 0, so one adder handles both addition and subtraction. For the compare, the datapath forms A minus B and corrects its sign for signed overflow. That corrected sign feeds the "less" input of slice 0, and the "less" input of every other slice is held at zero.

Top module: `aluTop`

## Requirements
- R1: Function code 3'b000 gives the bitwise AND of A and B. Overflow and carry-out are 0.
- R2: Function code 3'b001 gives the bitwise OR of A and B. Overflow and carry-out are 0.
- R3: Function code 3'b010 gives (A + B) mod 2^WIDTH. Carry-out is the unsigned carry out of the top bit.
- R4: Function code 3'b110 gives (A - B) mod 2^WIDTH, computed as A + ~B + 1. Carry-out is 1 exactly when A >= B as unsigned numbers.
- R5: Function code 3'b111 puts 1 in result bit 0 when A < B as signed two's complement numbers, and 0 otherwise. All higher result bits are 0. This holds even when A - B overflows.
- R6: The zero flag is 1 exactly when every result bit is 0.
- R7: The overflow flag is 1 only for codes 3'b010, 3'b110 and 3'b111, and only when the signed value of A+B (for 3'b010) or A-B (for 3'b110 and 3'b111) cannot be represented in WIDTH bits.
- R8: For code 3'b111, carry-out follows the same rule as for subtraction.
- R9: Any other function code (3'b011, 3'b100, 3'b101) drives the result to 0 and both overflow and carry-out to 0, so the zero flag is 1.
- R10: The behaviour above holds for any WIDTH of 2 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Operand A |
| opB | input | WIDTH | Operand B |
| opCode | input | 3 | Function select |
| result | output | WIDTH | Result word |
| isZero | output | 1 | All result bits are zero |
| overflow | output | 1 | Signed overflow of add, subtract or compare |
| carryOut | output | 1 | Carry out of the most significant slice |

## Verification
A 4-bit copy of the unit is driven with every operand pair under all eight function codes. This exposes any wrong carry into or out of a slice, any wrong mux select, and any leak from the reserved codes. It also covers every signed overflow case, including the most negative value minus one and the most positive value plus one. A 32-bit copy is then driven with edge operands (0, all ones, the signed limits, single bits) and with pseudo-random pairs. This separates a correct overflow rule (carry into the top bit versus carry out of it) from the plain carry-out. It also separates the overflow-corrected compare from a compare that looks only at the raw sign of the difference.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } aluOpE;

  typedef enum logic [1:0] {
    SEL_AND  = 2'd0,
    SEL_OR   = 2'd1,
    SEL_SUM  = 2'd2,
    SEL_LESS = 2'd3
  } outSelE;

  typedef struct packed {
    logic   bNegate;
    outSelE outSel;
    logic   arith;
    logic   valid;
  } aluCtrlT;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [2:0] opCode,
  output aluCtrlT    ctrl
);

  always_comb begin
    ctrl.bNegate = 1'b0;
    ctrl.outSel  = SEL_AND;
    ctrl.arith   = 1'b0;
    ctrl.valid   = 1'b1;
    case (opCode)
      OP_AND: ctrl.outSel = SEL_AND;
      OP_OR:  ctrl.outSel = SEL_OR;
      OP_ADD: begin
        ctrl.outSel = SEL_SUM;
        ctrl.arith  = 1'b1;
      end
      OP_SUB: begin
        ctrl.outSel  = SEL_SUM;
        ctrl.bNegate = 1'b1;
        ctrl.arith   = 1'b1;
      end
      OP_SLT: begin
        ctrl.outSel  = SEL_LESS;
        ctrl.bNegate = 1'b1;
        ctrl.arith   = 1'b1;
      end
      default: ctrl.valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/aluSlice.sv
module aluSlice
  import aluPkg::*;
(
  input  logic   aBit,
  input  logic   bBit,
  input  logic   bNegate,
  input  logic   carryIn,
  input  logic   lessIn,
  input  outSelE outSel,
  output logic   genBit,
  output logic   propBit,
  output logic   resBit
);

  logic bEff;

  assign bEff    = bBit ^ bNegate;
  assign genBit  = aBit & bEff;
  assign propBit = aBit ^ bEff;

  always_comb begin
    case (outSel)
      SEL_AND: resBit = aBit & bBit;
      SEL_OR:  resBit = aBit | bBit;
      SEL_SUM: resBit = propBit ^ carryIn;
      default: resBit = lessIn;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrlT          ctrl,
  output logic [WIDTH-1:0] result,
  output logic             isZero,
  output logic             overflow,
  output logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] genVec;
  logic [WIDTH-1:0] propVec;
  logic [WIDTH-1:0] sliceRes;
  logic [WIDTH-1:0] lessVec;
  logic [WIDTH:0]   carry;
  logic             ovfRaw;
  logic             setBit;

  always_comb begin
    logic [WIDTH:0] cTmp;
    cTmp[0] = ctrl.bNegate;
    for (int i = 0; i < WIDTH; i++) begin
      cTmp[i+1] = genVec[i] | (propVec[i] & cTmp[i]);
    end
    carry = cTmp;
  end

  assign ovfRaw  = carry[WIDTH] ^ carry[MSB];
  assign setBit  = propVec[MSB] ^ carry[MSB] ^ ovfRaw;
  assign lessVec = {{(WIDTH-1){1'b0}}, setBit};

  for (genvar i = 0; i < WIDTH; i++) begin : gSlice
    aluSlice uSlice (
      .aBit    (opA[i]),
      .bBit    (opB[i]),
      .bNegate (ctrl.bNegate),
      .carryIn (carry[i]),
      .lessIn  (lessVec[i]),
      .outSel  (ctrl.outSel),
      .genBit  (genVec[i]),
      .propBit (propVec[i]),
      .resBit  (sliceRes[i])
    );
  end

  assign result   = ctrl.valid ? sliceRes : '0;
  assign isZero   = ~|result;
  assign overflow = ctrl.arith & ovfRaw;
  assign carryOut = ctrl.arith & carry[WIDTH];

endmodule

// File: rtl/aluTop.sv
module aluTop
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             isZero,
  output logic             overflow,
  output logic             carryOut
);

  aluCtrlT ctrl;

  aluControl uCtrl (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  aluDatapath #(.WIDTH(WIDTH)) uPath (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .isZero   (isZero),
    .overflow (overflow),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/aluChecker.sv
module aluChecker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opCode,
  input logic [WIDTH-1:0] result,
  input logic             isZero,
  input logic             overflow,
  input logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    assert_zero_flag_R6: assert (isZero == (result == '0))
      else $error("zero flag disagrees with result");
    assert_and_value_R1: assert (opCode != 3'b000 || (result == (opA & opB) && !overflow && !carryOut))
      else $error("AND result or flags wrong");
    assert_or_value_R2: assert (opCode != 3'b001 || (result == (opA | opB) && !overflow && !carryOut))
      else $error("OR result or flags wrong");
    assert_slt_upper_R5: assert (opCode != 3'b111 || result[MSB:1] == '0)
      else $error("compare upper bits not zero");
    assert_unused_quiet_R9: assert (!(opCode == 3'b011 || opCode == 3'b100 || opCode == 3'b101)
                                    || (result == '0 && !overflow && !carryOut))
      else $error("reserved code not quiet");
    assert_add_overflow_R7: assert (opCode != 3'b010 || !overflow
                                    || (opA[MSB] == opB[MSB] && result[MSB] != opA[MSB]))
      else $error("add overflow without sign pattern");
    assert_sub_overflow_R7: assert (opCode != 3'b110 || !overflow
                                    || (opA[MSB] != opB[MSB] && result[MSB] != opA[MSB]))
      else $error("sub overflow without sign pattern");
  end

endmodule

bind aluTop aluChecker #(.WIDTH(WIDTH)) uChk (
  .opA      (opA),
  .opB      (opB),
  .opCode   (opCode),
  .result   (result),
  .isZero   (isZero),
  .overflow (overflow),
  .carryOut (carryOut)
);

// File: tb/sim_aluTop.sv
module sim_aluTop;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  a4, b4, r4;
  logic [31:0] a32, b32, r32;
  logic [2:0]  op4, op32;
  logic        z4, v4, c4, z32, v32, c32;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  aluTop #(.WIDTH(4)) u0 (
    .opA(a4), .opB(b4), .opCode(op4),
    .result(r4), .isZero(z4), .overflow(v4), .carryOut(c4)
  );

  aluTop #(.WIDTH(32)) u1 (
    .opA(a32), .opB(b32), .opCode(op32),
    .result(r32), .isZero(z32), .overflow(v32), .carryOut(c32)
  );

  function automatic longint sx(longint v, int w);
    return (v >= (64'sd1 <<< (w - 1))) ? v - (64'sd1 <<< w) : v;
  endfunction

  function automatic bit outOfRange(longint v, int w);
    return (v > ((64'sd1 <<< (w - 1)) - 1)) || (v < -(64'sd1 <<< (w - 1)));
  endfunction

  function automatic string tagOf(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3/R7";
      6: return "R4/R7";
      7: return "R5/R7/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic checkOne(int w, longint a, longint b, int op,
                          longint gotR, bit gotZ, bit gotV, bit gotC);
    longint mask, s, er;
    bit ev, ec, ez;
    mask = (64'sd1 <<< w) - 1;
    er = 0; ev = 0; ec = 0;
    case (op)
      0: er = a & b;
      1: er = a | b;
      2: begin
        s  = a + b;
        er = s & mask;
        ec = s[w];
        ev = outOfRange(sx(a, w) + sx(b, w), w);
      end
      6, 7: begin
        s  = a + ((~b) & mask) + 1;
        ec = s[w];
        ev = outOfRange(sx(a, w) - sx(b, w), w);
        er = (op == 6) ? (s & mask) : longint'(sx(a, w) < sx(b, w));
      end
      default: er = 0;
    endcase
    ez = (er == 0);
    checks++;
    if (gotR != er || gotZ != ez || gotV != ev || gotC != ec) begin
      fails++;
      $display("FAIL %s R6 R10 w=%0d op=%0d a=%h b=%h : got r=%h z=%0b v=%0b c=%0b exp r=%h z=%0b v=%0b c=%0b",
               tagOf(op), w, op, a, b, gotR, gotZ, gotV, gotC, er, ez, ev, ec);
    end
  endtask

  task automatic run32(logic [31:0] a, logic [31:0] b);
    for (int op = 0; op < 8; op++) begin
      @(posedge clk);
      a32 = a; b32 = b; op32 = 3'(op);
      @(negedge clk);
      checkOne(32, longint'(a), longint'(b), op, longint'(r32), z32, v32, c32);
    end
  endtask

  initial begin
    logic [31:0] edges [8];
    a4 = '0; b4 = '0; op4 = '0;
    a32 = '0; b32 = '0; op32 = '0;
    @(negedge clk);
    // Initial state, all-zero inputs under AND: result 0, zero flag set (R1, R6)
    checkOne(4, 0, 0, 0, longint'(r4), z4, v4, c4);
    checkOne(32, 0, 0, 0, longint'(r32), z32, v32, c32);

    // R10: exhaustive 4-bit sweep over every code and operand pair
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          a4 = 4'(a); b4 = 4'(b); op4 = 3'(op);
          @(negedge clk);
          checkOne(4, longint'(a), longint'(b), op, longint'(r4), z4, v4, c4);
        end
      end
    end

    // 32-bit edge operands: signed limits, all ones, single bits (R3 R4 R5 R7 R8)
    edges[0] = 32'h0000_0000; edges[1] = 32'hFFFF_FFFF;
    edges[2] = 32'h7FFF_FFFF; edges[3] = 32'h8000_0000;
    edges[4] = 32'h0000_0001; edges[5] = 32'h8000_0001;
    edges[6] = 32'h7FFF_FFFE; edges[7] = 32'h5555_AAAA;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run32(edges[i], edges[j]);

    // 32-bit pseudo-random operands
    for (int k = 0; k < 300; k++)
      run32($urandom, $urandom);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule